// File: doc/BRIEF.md
# Access-Code Write-Protection Gate

This block decides, request by request, whether a read, program or erase of a small nonvolatile array may proceed. It sits behind a serial command decoder, which hands it already-framed commands, and in front of the array model, which acts only on a grant. The block keeps three pieces of state in plain registers: a variable-length user access code, a protection mode (open or locked), and a boundary pointer. The pointer splits the address space. Everything below the boundary is read-only. Everything at or above it is fully writable while the block is open, and reachable only after a correct code has been presented while it is locked.

The command side has five operations: set the boundary, arm a single-use override, read back the boundary, present a code to unlock, and load a new code. An armed override lets exactly one program or erase land below the boundary, and then protection returns by itself. Unlocking holds only while chip select stays high. A failed code check raises a flag for the status logic.

Top module: `acc_guard`

## Requirements
- R1: After a synchronous reset the block is open (`locked`=0), the boundary is address 0, no override is armed, no access is granted and `code_fail`=0.
- R2: While open, a read is granted at any address. A program or erase (`req_kind` 1 or 2) is granted at addresses at or above the boundary and denied below it unless an override is armed.
- R3: A set-boundary command (`cmd_op`=0), when permitted, loads `cmd_addr` into the boundary. Nothing else changes it. A read-boundary command (`cmd_op`=2) drives the boundary onto `ptr_rd_data` with `ptr_rd_valid` high one cycle after the command.
- R4: After an override command (`cmd_op`=1) is accepted, the next program or erase below the boundary is granted. The override is then consumed, and later program or erase requests below the boundary are denied. Program or erase requests at or above the boundary do not consume it.
- R5: A load-code command (`cmd_op`=4) with `cmd_len` from 1 to 8 stores the low `cmd_len` bytes of `cmd_code` and locks the block. A length of 0 opens it. A length above 8 is rejected and changes nothing. A load also drops any granted access. While the block is locked and access is not granted, a load is rejected.
- R6: While locked, every request at or above the boundary is denied without granted access and granted with it. Reads below the boundary are always granted. Program and erase below the boundary still need an armed override.
- R7: An unlock command (`cmd_op`=3) while locked grants access only if `cmd_len` equals the stored length and bytes 0 to len-1 of `cmd_code` (byte i in bits 8i+7:8i) all match. Higher bytes are ignored. On a mismatch, access stays off and `code_fail` rises. On a match, `code_fail` clears. While open, an unlock command has no effect.
- R8: While locked without granted access, set-boundary and override commands are rejected. `cmd_reject` pulses one cycle after the command, and the boundary and override state stay unchanged.
- R9: When `cs` is low, granted access is withdrawn at the next clock edge, and commands presented while `cs` is low are ignored.
- R10: Every request cycle (`req_valid`=1) is answered by `resp_valid`=1 exactly one cycle later, with `resp_grant` carrying the decision. `resp_valid` is 0 in cycles that answer no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select; low withdraws access and blocks commands |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 set boundary, 1 override, 2 read boundary, 3 unlock, 4 load code |
| cmd_addr | input | ADDR_W | Boundary value for a set-boundary command |
| cmd_len | input | LEN_W | Code length in bytes for unlock and load |
| cmd_code | input | 8*MAX_BYTES | Code bytes, byte 0 in the low bits |
| req_valid | input | 1 | Array request strobe |
| req_kind | input | 2 | 0 read, 1 program, 2 erase |
| req_addr | input | ADDR_W | Array address of the request |
| resp_valid | output | 1 | Decision valid, one cycle after a request |
| resp_grant | output | 1 | 1 grants the request, 0 denies it |
| cmd_reject | output | 1 | Pulse: the previous command was refused |
| ptr_rd_valid | output | 1 | Pulse: `ptr_rd_data` holds the boundary |
| ptr_rd_data | output | ADDR_W | Boundary value read back |
| locked | output | 1 | 1 while an access code is loaded |
| code_fail | output | 1 | Last unlock attempt mismatched |

## Verification
The bench goes after the single-use nature of the override. A design that forgets to clear it would grant a second write into the read-only region, and one that clears it on a write above the boundary would deny a legitimate one. Unlock attempts are made with the right bytes but the wrong length, with one wrong byte, and with junk above the stated length. A comparator that ignores length or compares all eight bytes gives the wrong grant on a following request. Locked-mode rejection is checked by reading the boundary back after a refused set-boundary command. Chip-select drop and zero-length loads are checked through later grants, because a design that keeps access alive or stays locked then answers with the wrong decision.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    typedef enum logic [2:0] {
        OP_SET_PTR = 3'd0,
        OP_OVR     = 3'd1,
        OP_RD_PTR  = 3'd2,
        OP_UNLOCK  = 3'd3,
        OP_LOAD    = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_PROG  = 2'd1,
        RQ_ERASE = 2'd2
    } req_kind_e;

    function automatic logic is_modify(input logic [1:0] kind);
        return kind != RQ_READ;
    endfunction

endpackage

// File: rtl/acc_guard_code_bank.sv
module acc_guard_code_bank #(
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs,
    input  logic                   load_en,
    input  logic [LEN_W-1:0]       load_len,
    input  logic [8*MAX_BYTES-1:0] load_code,
    input  logic                   chk_en,
    input  logic [LEN_W-1:0]       chk_len,
    input  logic [8*MAX_BYTES-1:0] chk_code,
    output logic                   locked,
    output logic                   access_ok,
    output logic                   code_fail
);
    logic [8*MAX_BYTES-1:0] code_q;
    logic [LEN_W-1:0]       len_q;
    logic [MAX_BYTES-1:0]   byte_ok;
    logic                   match;

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        assign byte_ok[i] = (LEN_W'(i) >= len_q) ||
                            (code_q[8*i +: 8] == chk_code[8*i +: 8]);
    end

    assign match = (chk_len == len_q) && (&byte_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q    <= '0;
            len_q     <= '0;
            locked    <= 1'b0;
            access_ok <= 1'b0;
            code_fail <= 1'b0;
        end else begin
            if (load_en) begin
                code_q    <= load_code;
                len_q     <= load_len;
                locked    <= (load_len != '0);
                access_ok <= 1'b0;
                code_fail <= 1'b0;
            end else if (chk_en) begin
                access_ok <= match;
                code_fail <= !match;
            end
            if (!cs) begin
                access_ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acc_guard_ptr_unit.sv
module acc_guard_ptr_unit #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              ovr_set,
    input  logic              ovr_use,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] ptr,
    output logic              ovr_armed,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            ovr_armed <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (wr_en) ptr <= wr_addr;
            if (ovr_set)      ovr_armed <= 1'b1;
            else if (ovr_use) ovr_armed <= 1'b0;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= ptr;
        end
    end
endmodule

// File: rtl/acc_guard_judge.sv
module acc_guard_judge
    import acc_guard_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              priv_ok,
    input  logic              ovr_armed,
    output logic              grant,
    output logic              uses_ovr
);
    logic below;

    always_comb begin
        below    = addr < ptr;
        uses_ovr = 1'b0;
        if (!below) begin
            grant = priv_ok;
        end else if (!is_modify(kind)) begin
            grant = 1'b1;
        end else begin
            grant    = ovr_armed;
            uses_ovr = ovr_armed;
        end
    end
endmodule

// File: rtl/acc_guard.sv
module acc_guard
    import acc_guard_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [LEN_W-1:0]       cmd_len,
    input  logic [8*MAX_BYTES-1:0] cmd_code,
    input  logic                   req_valid,
    input  logic [1:0]             req_kind,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   resp_valid,
    output logic                   resp_grant,
    output logic                   cmd_reject,
    output logic                   ptr_rd_valid,
    output logic [ADDR_W-1:0]      ptr_rd_data,
    output logic                   locked,
    output logic                   code_fail
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

    logic              access_ok, ovr_armed, priv_ok;
    logic [ADDR_W-1:0] ptr_q;
    logic              go, is_set, is_ovr, is_rd, is_unl, is_load;
    logic              set_ok, ovr_ok, load_ok, unl_ok, reject_d;
    logic              grant, uses_ovr;

    assign priv_ok = !locked || access_ok;
    assign go      = cmd_valid && cs;
    assign is_set  = go && (cmd_op == OP_SET_PTR);
    assign is_ovr  = go && (cmd_op == OP_OVR);
    assign is_rd   = go && (cmd_op == OP_RD_PTR);
    assign is_unl  = go && (cmd_op == OP_UNLOCK);
    assign is_load = go && (cmd_op == OP_LOAD);

    assign set_ok   = is_set && priv_ok;
    assign ovr_ok   = is_ovr && priv_ok;
    assign load_ok  = is_load && priv_ok && (cmd_len <= LEN_MAX);
    assign unl_ok   = is_unl && locked;
    assign reject_d = (is_set && !set_ok) || (is_ovr && !ovr_ok) ||
                      (is_load && !load_ok);

    acc_guard_code_bank #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_code (
        .clk(clk), .rst(rst), .cs(cs),
        .load_en(load_ok), .load_len(cmd_len), .load_code(cmd_code),
        .chk_en(unl_ok), .chk_len(cmd_len), .chk_code(cmd_code),
        .locked(locked), .access_ok(access_ok), .code_fail(code_fail)
    );

    acc_guard_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst),
        .wr_en(set_ok), .wr_addr(cmd_addr),
        .ovr_set(ovr_ok), .ovr_use(req_valid && uses_ovr),
        .rd_en(is_rd),
        .ptr(ptr_q), .ovr_armed(ovr_armed),
        .rd_valid(ptr_rd_valid), .rd_data(ptr_rd_data)
    );

    acc_guard_judge #(.ADDR_W(ADDR_W)) u_judge (
        .kind(req_kind), .addr(req_addr), .ptr(ptr_q),
        .priv_ok(priv_ok), .ovr_armed(ovr_armed),
        .grant(grant), .uses_ovr(uses_ovr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= req_valid && grant;
            cmd_reject <= reject_d;
        end
    end
endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk
    import acc_guard_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_grant,
    input logic              cmd_reject,
    input logic              locked,
    input logic              access_ok,
    input logic              ovr_armed,
    input logic [ADDR_W-1:0] ptr_q
);
    a_r1_reset_open: assert property (@(posedge clk)
        $past(rst) |-> (!locked && !access_ok && !ovr_armed && ptr_q == '0));

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r6_read_low_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == RQ_READ && req_addr < ptr_q) |=> resp_grant);

    a_r2_low_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != RQ_READ && req_addr < ptr_q && !ovr_armed)
        |=> !resp_grant);

    a_r4_override_once: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != RQ_READ && req_addr < ptr_q && ovr_armed &&
         !(cmd_valid && cs && cmd_op == OP_OVR)) |=> !ovr_armed);

    a_r6_locked_high_denied: assert property (@(posedge clk) disable iff (rst)
        (req_valid && locked && !access_ok && req_addr >= ptr_q) |=> !resp_grant);

    a_r8_ptr_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cs && cmd_op == OP_SET_PTR && locked && !access_ok)
        |=> ($stable(ptr_q) && cmd_reject));

    a_r9_cs_drop: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !access_ok);
endmodule

bind acc_guard acc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .cmd_reject(cmd_reject),
    .locked(locked), .access_ok(access_ok), .ovr_armed(ovr_armed), .ptr_q(ptr_q)
);

// File: tb/acc_guard_tb.sv
module acc_guard_tb;
    import acc_guard_pkg::*;

    localparam int ADDR_W = 9;
    localparam int MAXB   = 8;
    localparam int LEN_W  = $clog2(MAXB + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [8*MAXB-1:0] cmd_code = '0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid, resp_grant, cmd_reject, ptr_rd_valid;
    logic [ADDR_W-1:0] ptr_rd_data;
    logic              locked, code_fail;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_guard #(.ADDR_W(ADDR_W), .MAX_BYTES(MAXB)) u_dut (
        .clk(clk), .rst(rst), .cs(cs), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_code(cmd_code),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .cmd_reject(cmd_reject),
        .ptr_rd_valid(ptr_rd_valid), .ptr_rd_data(ptr_rd_data),
        .locked(locked), .code_fail(code_fail)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cmd(input cmd_op_e op, input int addr, input int len,
                       input logic [8*MAXB-1:0] code, input int exp_rej, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(addr);
        cmd_len = LEN_W'(len); cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, int'(cmd_reject), exp_rej);
    endtask

    task automatic req(input req_kind_e k, input int addr, input int exp_g, input string r);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", int'(resp_valid), 1);
        chk(r, int'(resp_grant), exp_g);
    endtask

    task automatic read_ptr(input int exp, input string r);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_RD_PTR;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(r, int'(ptr_rd_valid), 1);
        chk(r, int'(ptr_rd_data), exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(locked), 0);
        chk("R1", int'(code_fail), 0);
        chk("R10", int'(resp_valid), 0);
        read_ptr(0, "R1");
    endtask

    task automatic t_open_regions;
        req(RQ_PROG, 5, 1, "R2");
        cmd(OP_SET_PTR, 100, 0, '0, 0, "R3");
        read_ptr(100, "R3");
        req(RQ_PROG, 50, 0, "R2");
        req(RQ_ERASE, 100, 1, "R2");
        req(RQ_READ, 50, 1, "R2");
    endtask

    task automatic t_override;
        cmd(OP_OVR, 0, 0, '0, 0, "R4");
        req(RQ_PROG, 200, 1, "R4");
        req(RQ_PROG, 20, 1, "R4");
        req(RQ_PROG, 20, 0, "R4");
        req(RQ_ERASE, 10, 0, "R4");
    endtask

    task automatic t_load;
        cmd(OP_LOAD, 0, 9, 64'h11_2233, 1, "R5");
        chk("R5", int'(locked), 0);
        cmd(OP_LOAD, 0, 3, 64'h11_2233, 0, "R5");
        chk("R5", int'(locked), 1);
    endtask

    task automatic t_locked;
        req(RQ_READ, 200, 0, "R6");
        req(RQ_PROG, 200, 0, "R6");
        req(RQ_READ, 50, 1, "R6");
        req(RQ_PROG, 50, 0, "R6");
        cmd(OP_SET_PTR, 300, 0, '0, 1, "R8");
        read_ptr(100, "R8");
        cmd(OP_OVR, 0, 0, '0, 1, "R8");
        req(RQ_PROG, 50, 0, "R8");
        cmd(OP_LOAD, 0, 0, '0, 1, "R5");
        chk("R5", int'(locked), 1);
    endtask

    task automatic t_unlock;
        cmd(OP_UNLOCK, 0, 2, 64'h11_2233, 0, "R7");
        chk("R7", int'(code_fail), 1);
        req(RQ_READ, 200, 0, "R7");
        cmd(OP_UNLOCK, 0, 3, 64'h11_2234, 0, "R7");
        chk("R7", int'(code_fail), 1);
        req(RQ_READ, 200, 0, "R7");
        cmd(OP_UNLOCK, 0, 3, 64'hABCD_EF00_0011_2233, 0, "R7");
        chk("R7", int'(code_fail), 0);
        req(RQ_READ, 200, 1, "R6");
        req(RQ_PROG, 200, 1, "R6");
        cmd(OP_SET_PTR, 300, 0, '0, 0, "R8");
        read_ptr(300, "R3");
    endtask

    task automatic t_cs_drop;
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
        cs = 1'b1;
        req(RQ_READ, 400, 0, "R9");
        @(negedge clk);
        cs = 1'b0;
        cmd_valid = 1'b1; cmd_op = OP_UNLOCK; cmd_len = 3; cmd_code = 64'h11_2233;
        @(negedge clk);
        cmd_valid = 1'b0; cs = 1'b1;
        req(RQ_READ, 400, 0, "R9");
    endtask

    task automatic t_reopen;
        cmd(OP_UNLOCK, 0, 3, 64'h11_2233, 0, "R7");
        cmd(OP_LOAD, 0, 0, '0, 0, "R5");
        chk("R5", int'(locked), 0);
        req(RQ_PROG, 400, 1, "R5");
        cmd(OP_UNLOCK, 0, 1, 64'h77, 0, "R7");
        chk("R7", int'(code_fail), 0);
        @(negedge clk);
        chk("R10", int'(resp_valid), 0);
    endtask

    initial begin
        t_reset();
        t_open_regions();
        t_override();
        t_load();
        t_locked();
        t_unlock();
        t_cs_drop();
        t_reopen();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule